// File: doc/BRIEF.md
# Slot-Scheduled Bus Arbiter with Round-Robin Reclaim

This block decides which master may drive a shared bus in each clock cycle. Every master raises its own request line and gets its own grant line back. Time is cut into slots of a fixed number of cycles, and a fixed number of slots makes one frame that repeats. A programmable table names the master that owns each slot. A master that needs more bandwidth can own several entries of the table.

In every cycle the owner of the current slot wins if it is requesting. If the owner is quiet, a second level picks another waiting master in round-robin order, so the cycle is still used. The round-robin pointer moves only when that second level grants. It then moves to the master just after the one it served. Software rewrites the table through a one-entry-per-cycle write port. Writes go into a staging copy, and that copy becomes active only when a frame ends. A frame that is running therefore always keeps the schedule it started with.

The grant is registered. Request lines seen at a clock edge produce the grant that is visible after that edge.

Top module: `tdma_rr_arbiter`

## Requirements
- R1: While the synchronous reset is high, every grant output is 0. The first cycle after reset is slot 0, and the round-robin pointer starts at master 0.
- R2: At most one grant bit is high in any cycle.
- R3: If no request line is high at a clock edge, no grant is high after that edge.
- R4: A grant goes only to a master whose request was high at the edge that produced it.
- R5: If the owner of the current slot is requesting, it gets the grant, whatever the other masters do.
- R6: Each slot lasts SLOT_CYCLES cycles. The slot index counts 0 to N_SLOTS-1 and then wraps to 0. After reset, table entry i holds master i mod N_MASTERS.
- R7: If the slot owner is not requesting, the grant goes to the first requesting master found by counting upward from the round-robin pointer, wrapping past N_MASTERS-1 to 0.
- R8: The round-robin pointer changes only on a round-robin grant. It then becomes the index of the winner plus one, wrapping to 0. A grant to the slot owner leaves the pointer as it was.
- R9: A table write (entry index on the address port, master index on the data port) does not affect the frame in progress. It takes effect from the first slot of the next frame. This includes a write made in the last cycle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_MASTERS | One request line per master |
| tbl_we | input | 1 | Write strobe for the staging slot table |
| tbl_addr | input | clog2(N_SLOTS) | Slot table entry to write |
| tbl_wdata | input | clog2(N_MASTERS) | Master index to store in that entry |
| gnt | output | N_MASTERS | One grant line per master, registered |

## Verification
The bench targets the following faults. When the slot owner is quiet, a reclaimed cycle must go to the right master. A design that skipped reclaim would leave the bus idle. A design that moved the pointer on owner grants would serve the wrong master on the next reclaimed cycle. The bench writes the whole table in the middle of a frame and again in the very last cycle of a frame. A design that let the running frame see new entries, or that dropped a write made on the boundary, would grant the wrong owner at once or one frame too late. It also runs cycles with no request at all and long stretches of random requests with random table writes. These catch a grant that stays high with nobody asking, a grant to a master that is not requesting, or two grants at once.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        GK_NONE = 2'd0,
        GK_SLOT = 2'd1,
        GK_RR   = 2'd2
    } grant_kind_e;
endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
    parameter int N_SLOTS     = 8,
    parameter int SLOT_CYCLES = 3,
    localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot_idx,
    output logic          frame_end
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [SW-1:0] slot;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic slot_end;

    always_comb begin
        tmr_d    = tmr_q;
        slot_end = (tmr_q.cnt == CW'(SLOT_CYCLES - 1));
        frame_end = slot_end && (tmr_q.slot == SW'(N_SLOTS - 1));
        if (slot_end) begin
            tmr_d.cnt  = '0;
            tmr_d.slot = frame_end ? '0 : tmr_q.slot + SW'(1);
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign slot_idx = tmr_q.slot;

    // R6: the slot index holds inside a slot and wraps after the last one
    a_r6_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (tmr_q.cnt != CW'(SLOT_CYCLES - 1)) |=> $stable(tmr_q.slot));
    a_r6_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (tmr_q.slot == '0 && tmr_q.cnt == '0));
endmodule

// File: rtl/arb_slot_table.sv
module arb_slot_table #(
    parameter int N_MASTERS = 4,
    parameter int N_SLOTS   = 8,
    localparam int OW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
    localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [OW-1:0] wdata,
    input  logic          frame_end,
    input  logic [SW-1:0] rd_idx,
    output logic [OW-1:0] owner
);
    typedef struct packed {
        logic [N_SLOTS-1:0][OW-1:0] stage;
        logic [N_SLOTS-1:0][OW-1:0] live;
    } tbl_t;

    tbl_t tbl_d, tbl_q, tbl_rst;

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            tbl_rst.stage[i] = OW'(i % N_MASTERS);
            tbl_rst.live[i]  = OW'(i % N_MASTERS);
        end
    end

    always_comb begin
        tbl_d = tbl_q;
        if (we && (int'(waddr) < N_SLOTS) && (int'(wdata) < N_MASTERS))
            tbl_d.stage[waddr] = wdata;
        if (frame_end)
            tbl_d.live = tbl_d.stage;
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= tbl_rst;
        else     tbl_q <= tbl_d;
    end

    assign owner = tbl_q.live[rd_idx];

    // R9: the live schedule only changes at a frame boundary
    a_r9_live_frozen: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(tbl_q.live));
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N_MASTERS = 4,
    localparam int OW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [OW-1:0]        ptr,
    output logic                 found,
    output logic [OW-1:0]        winner
);
    always_comb begin
        int idx;
        found  = 1'b0;
        winner = '0;
        for (int k = N_MASTERS - 1; k >= 0; k--) begin
            idx = (int'(ptr) + k) % N_MASTERS;
            if (req[idx]) begin
                found  = 1'b1;
                winner = OW'(idx);
            end
        end
    end
endmodule

// File: rtl/tdma_rr_arbiter.sv
module tdma_rr_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS   = 4,
    parameter int N_SLOTS     = 8,
    parameter int SLOT_CYCLES = 3,
    localparam int OW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
    localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 tbl_we,
    input  logic [SW-1:0]        tbl_addr,
    input  logic [OW-1:0]        tbl_wdata,
    output logic [N_MASTERS-1:0] gnt
);
    typedef struct packed {
        logic [N_MASTERS-1:0] gnt;
        logic [OW-1:0]        ptr;
    } arb_t;

    arb_t        arb_d, arb_q;
    logic [SW-1:0] slot_idx;
    logic          frame_end;
    logic [OW-1:0] owner;
    logic          owner_req;
    logic          rr_found;
    logic [OW-1:0] rr_winner;
    grant_kind_e   kind;

    arb_slot_timer #(.N_SLOTS(N_SLOTS), .SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .slot_idx(slot_idx), .frame_end(frame_end));

    arb_slot_table #(.N_MASTERS(N_MASTERS), .N_SLOTS(N_SLOTS)) u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
        .frame_end(frame_end), .rd_idx(slot_idx), .owner(owner));

    arb_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
        .req(req), .ptr(arb_q.ptr), .found(rr_found), .winner(rr_winner));

    assign owner_req = req[owner];

    always_comb begin
        arb_d     = arb_q;
        arb_d.gnt = '0;
        if (owner_req)     kind = GK_SLOT;
        else if (rr_found) kind = GK_RR;
        else               kind = GK_NONE;
        case (kind)
            GK_SLOT: arb_d.gnt[owner] = 1'b1;
            GK_RR: begin
                arb_d.gnt[rr_winner] = 1'b1;
                arb_d.ptr = (int'(rr_winner) == N_MASTERS - 1) ? '0
                          : rr_winner + OW'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) arb_q <= '0;
        else     arb_q <= arb_d;
    end

    assign gnt = arb_q.gnt;

    // R2: never more than one grant
    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    // R3: no request, no grant
    a_r3_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> (gnt == '0));
    // R4: grant only to a master that was asking
    a_r4_grant_to_requester: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gnt & ~$past(req)) == '0));
    // R5: a requesting slot owner always wins
    a_r5_owner_wins: assert property (@(posedge clk) disable iff (rst)
        owner_req |=> (gnt != '0));
    // R8: pointer moves only on a reclaimed grant
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (owner_req || !rr_found) |=> $stable(arb_q.ptr));
endmodule

// File: tb/sim_tdma_rr_arbiter.sv
`timescale 1ns/1ps
module sim_tdma_rr_arbiter;
    localparam int N   = 4;
    localparam int NS  = 8;
    localparam int LEN = 3;
    localparam int FRAME = NS * LEN;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic         tbl_we = 1'b0;
    logic [2:0]   tbl_addr = '0;
    logic [1:0]   tbl_wdata = '0;
    logic [N-1:0] gnt;

    tdma_rr_arbiter #(.N_MASTERS(N), .N_SLOTS(NS), .SLOT_CYCLES(LEN)) u0 (
        .clk(clk), .rst(rst), .req(req), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .gnt(gnt));

    always #5 clk = ~clk;

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } item_t;
    item_t sb_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int m_stage [NS];
    int m_live  [NS];
    int m_ptr;
    int e;

    task automatic report(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected=%b (edge %0d)", tag, act, exp, e);
        end
    endtask

    function automatic logic [N-1:0] predict(logic [N-1:0] r);
        int own;
        logic [N-1:0] x;
        x = '0;
        own = m_live[(e / LEN) % NS];
        if (r[own]) x[own] = 1'b1;
        else begin
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (m_ptr + k) % N;
                if (r[idx]) begin
                    x[idx] = 1'b1;
                    m_ptr = (idx + 1) % N;
                    break;
                end
            end
        end
        return x;
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic step(logic [N-1:0] r, bit we, int a, int d, string tag);
        item_t it;
        req = r; tbl_we = we; tbl_addr = 3'(a); tbl_wdata = 2'(d);
        it.exp = predict(r);
        it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        if (we) m_stage[a] = d;
        if (e % FRAME == FRAME - 1)
            for (int i = 0; i < NS; i++) m_live[i] = m_stage[i];
        e++;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                report(it.tag, gnt, it.exp);
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_stage[i] = i % N;
            m_live[i]  = i % N;
        end
        m_ptr = 0;
        e = 0;
        // R1: grants held low during reset even with everyone asking
        req = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        report("R1", gnt, '0);
        rst = 1'b0;

        // R1 R5 R6: all requesting, owners follow default table
        repeat (2 * FRAME) step('1, 0, 0, 0, "R1 R5 R6");
        // R7 R8: master 0 quiet, its slots are reclaimed in rotation
        repeat (FRAME) step(4'b1110, 0, 0, 0, "R7 R8");
        // R7 R8: only masters 0 and 2 asking
        repeat (FRAME) step(4'b0101, 0, 0, 0, "R7 R8");
        // R3: nobody asking
        repeat (LEN * 2) step('0, 0, 0, 0, "R3");
        // R9: rewrite whole table mid-frame; current frame keeps old owners
        while (e % FRAME != 5) step('1, 0, 0, 0, "R9");
        for (int i = 0; i < NS; i++) step('1, 1, i, 3, "R9");
        repeat (FRAME + 4) step('1, 0, 0, 0, "R9");
        // R9: write issued on the last cycle of a frame
        while (e % FRAME != FRAME - 1) step('1, 0, 0, 0, "R9");
        step('1, 1, 0, 1, "R9");
        repeat (LEN + 1) step('1, 0, 0, 0, "R9");
        // R2 R4 R5 R7: random requests with occasional table writes
        for (int i = 0; i < 600; i++) begin
            bit w;
            w = ($urandom % 8) == 0;
            step(4'($urandom), w, int'($urandom % NS), int'($urandom % N),
                 "R2 R4 R5 R7");
        end
        step('0, 0, 0, 0, "R3");
        @(negedge clk);
        finish_run();
    end
endmodule